// File: doc/BRIEF.md
# NAND Hamming ECC Generator

This block sits beside the byte-wide data path of a NAND flash controller and builds a Hamming-style check code over each 512-byte segment that passes through it. The segment is handled as two independent 256-byte halves. Each half yields three code bytes: two bytes of line parity (sixteen bits, split by byte address) and one byte of column parity (six bits, split by bit position, with the two lowest bits tied to 1). All code bytes are stored inverted, so an erased half of all-0xFF data gives an all-0xFF code. Software compares a stored code with a freshly computed one and corrects any single-bit error per half itself. Correction is outside this block.

Software drives the block by writing mode values. A clear command wipes both accumulators and the byte counter. One dummy read of the data register must then arm the engine before a calculate command starts accumulation. Each accepted byte goes to the first half for counter values 0 to 255 and to the second half for 256 to 511. Later bytes are dropped until the next clear. A result command turns the data register into a readout of three 16-bit words, and each read moves to the next word.

The controller has five named states. IDLE is the state after reset and after any unrecognised mode value. CLEARED is entered on a clear command. PRIMED is entered from CLEARED on the dummy read. CALC is entered on a calculate command from any state except CLEARED. RESULT is entered on a result command from any state. A calculate command while in CLEARED leaves the state in CLEARED.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset the state is IDLE, `rd_data` reads 0, and both accumulators are cleared, so a later result readout gives 0xFFFF for all three words.
- R2: A mode write of 0xF4 clears both accumulators and the byte counter and enters CLEARED.
- R3: In CLEARED a calculate write (0xB4) is ignored, and bytes are not accumulated. Only a read strobe (`rd_stb`) moves the engine to PRIMED.
- R4: A mode write of 0xB4 from PRIMED, CALC, IDLE or RESULT enters CALC. A byte with `byte_vld` high is accumulated only in CALC.
- R5: Accepted bytes with counter values 0..255 update only the first-half code. Values 256..511 update only the second-half code. The address within the half is the counter value modulo 256.
- R6: After 512 accepted bytes, further bytes are ignored until the next 0xF4 write.
- R7: The raw line-parity bit LP(2k+1) is the XOR of the parities of the bytes whose in-half address bit k is 1. LP(2k) is the same over the bytes whose address bit k is 0, for k = 0..7.
- R8: The raw column-parity bit CP(2j+1) is the XOR over all bytes of the data bits whose bit index has bit j set. CP(2j) covers the bit indices with bit j clear, for j = 0..2. The column code byte is {~CP5..~CP0, 1, 1}.
- R9: Line-parity code bytes are the bitwise inverse of raw parity. Erased (0xFF) data yields code 0xFF in every byte.
- R10: A mode write of 0xD4 enters RESULT and selects word 0. Word 0 is {A.LP15-8, A.LP7-0}, word 1 is {B.LP7-0, A.col}, and word 2 is {B.col, B.LP15-8}, each written {high byte, low byte}, where A is the first half and B the second. Each `rd_stb` in RESULT advances 0→1→2→0.
- R11: Any other mode value enters IDLE. Accumulation stops, the codes are held, and `rd_data` reads 0 outside RESULT.
- R12: When `mode_we` and `byte_vld` are high in the same cycle, the byte is not accumulated. When `mode_we` and `rd_stb` are high together, the mode write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| rd_stb | input | 1 | Data register read strobe |
| byte_vld | input | 1 | A data byte passes on the NAND path this cycle |
| byte_dat | input | 8 | The passing data byte |
| rd_data | output | 16 | Result word in RESULT, otherwise 0 |

## Verification
The hardest case to reach from the ports is the switch from the first to the second half at byte 256, and the saturation at byte 512 that follows it. Both need a full run of more than five hundred accepted bytes, with the right clear, dummy read and calculate sequence ahead of them. The stimulus streams 532 varied bytes through one armed segment and then reads all three words, including the wrap-around read. Separate short runs place a single set bit at a chosen address, so that each line and column parity bit can be predicted by hand. A behavioural model of the counter and the stored bytes is compared with `rd_data` on every clock.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
    localparam int DATA_W     = 8;
    localparam int HALF_BYTES = 256;
    localparam int HALVES     = 2;
    localparam int WORD_W     = 16;

    localparam logic [7:0] MODE_CLEAR  = 8'hF4;
    localparam logic [7:0] MODE_CALC   = 8'hB4;
    localparam logic [7:0] MODE_RESULT = 8'hD4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEARED,
        ST_PRIMED,
        ST_CALC,
        ST_RESULT
    } ecc_state_t;
endpackage

// File: rtl/ecc_byte_sequencer.sv
module ecc_byte_sequencer
    import ecc_gen_pkg::*;
#(
    parameter int HALF_N = HALF_BYTES,
    parameter int N_HALF = HALVES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_we,
    input  logic [7:0]                  mode_val,
    input  logic                        rd_stb,
    input  logic                        byte_vld,
    output logic                        acc_clr,
    output logic                        acc_en,
    output logic                        half_sel,
    output logic [$clog2(HALF_N)-1:0]   byte_addr,
    output logic                        in_result,
    output logic [1:0]                  word_ptr
);
    localparam int ADDR_W = $clog2(HALF_N);
    localparam int LIMIT  = HALF_N * N_HALF;
    localparam int CNT_W  = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    ecc_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             is_clear, is_calc, is_result;

    assign is_clear  = mode_we && (mode_val == MODE_CLEAR);
    assign is_calc   = mode_we && (mode_val == MODE_CALC);
    assign is_result = mode_we && (mode_val == MODE_RESULT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (mode_we) begin
            if (is_clear)       st_d = ST_CLEARED;
            else if (is_result) st_d = ST_RESULT;
            else if (is_calc)   st_d = (st_q == ST_CLEARED) ? ST_CLEARED : ST_CALC;
            else                st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_CLEARED: if (rd_stb) st_d = ST_PRIMED;
                ST_IDLE, ST_PRIMED, ST_CALC, ST_RESULT: st_d = st_q;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_clr   = is_clear;
        acc_en    = (st_q == ST_CALC) && byte_vld && !mode_we && (cnt_q != LIMIT_C);
        half_sel  = cnt_q[ADDR_W];
        byte_addr = cnt_q[ADDR_W-1:0];
        in_result = (st_q == ST_RESULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (is_clear) cnt_q <= '0;
        else if (acc_en)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          word_ptr <= 2'd0;
        else if (is_result)  word_ptr <= 2'd0;
        else if (!mode_we && rd_stb && st_q == ST_RESULT)
            word_ptr <= (word_ptr == 2'd2) ? 2'd0 : word_ptr + 2'd1;
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |=> (cnt_q == '0) && (st_q == ST_CLEARED));
    assert_dummy_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLEARED && !rd_stb && !is_clear && !is_result && mode_val != 8'h00 && (is_calc || !mode_we))
        |=> st_q == ST_CLEARED);
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_CALC && !is_clear) |=> $stable(cnt_q));
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LIMIT_C && !is_clear) |=> cnt_q == LIMIT_C);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_C);
    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_ptr != 2'd3);
    assert_result_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_result |=> in_result && word_ptr == 2'd0);
    assert_other_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !is_clear && !is_calc && !is_result) |=> st_q == ST_IDLE);
endmodule

// File: rtl/ecc_half_accum.sv
module ecc_half_accum
    import ecc_gen_pkg::*;
#(
    parameter int HALF_N = HALF_BYTES,
    parameter int BYTE_W = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic [$clog2(HALF_N)-1:0]  addr,
    input  logic [BYTE_W-1:0]          dat,
    output logic [2*$clog2(HALF_N)-1:0] lp_code,
    output logic [2*$clog2(BYTE_W)+1:0] col_code
);
    localparam int ADDR_W = $clog2(HALF_N);
    localparam int LP_W   = 2 * ADDR_W;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int CP_W   = 2 * BIT_W;

    logic [LP_W-1:0] lp_q, lp_d;
    logic [CP_W-1:0] cp_q, cp_d;
    logic            par, hi_p, lo_p;

    always_comb begin
        par  = ^dat;
        lp_d = lp_q;
        cp_d = cp_q;
        hi_p = 1'b0;
        lo_p = 1'b0;
        for (int k = 0; k < ADDR_W; k++) begin
            if (addr[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ par;
            else         lp_d[2*k]   = lp_q[2*k]   ^ par;
        end
        for (int j = 0; j < BIT_W; j++) begin
            hi_p = 1'b0;
            lo_p = 1'b0;
            for (int i = 0; i < BYTE_W; i++) begin
                if (((i >> j) & 1) == 1) hi_p = hi_p ^ dat[i];
                else                     lo_p = lo_p ^ dat[i];
            end
            cp_d[2*j+1] = cp_q[2*j+1] ^ hi_p;
            cp_d[2*j]   = cp_q[2*j]   ^ lo_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (clr) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (en) begin
            lp_q <= lp_d;
            cp_q <= cp_d;
        end
    end

    assign lp_code  = ~lp_q;
    assign col_code = {~cp_q, 2'b11};

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(lp_q) && $stable(cp_q));
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lp_code == '1) && (col_code == '1));
endmodule

// File: rtl/ecc_word_mux.sv
module ecc_word_mux
    import ecc_gen_pkg::*;
(
    input  logic                     in_result,
    input  logic [1:0]               word_ptr,
    input  logic [HALVES-1:0][7:0]   lp_lo,
    input  logic [HALVES-1:0][7:0]   lp_hi,
    input  logic [HALVES-1:0][7:0]   col,
    output logic [WORD_W-1:0]        rd_data
);
    always_comb begin
        rd_data = '0;
        if (in_result) begin
            unique case (word_ptr)
                2'd0:    rd_data = {lp_hi[0], lp_lo[0]};
                2'd1:    rd_data = {lp_lo[1], col[0]};
                2'd2:    rd_data = {col[1], lp_hi[1]};
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import ecc_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [7:0]        mode_val,
    input  logic              rd_stb,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    output logic [WORD_W-1:0] rd_data
);
    localparam int ADDR_W = $clog2(HALF_BYTES);
    localparam int LP_W   = 2 * ADDR_W;
    localparam int COL_W  = 2 * $clog2(DATA_W) + 2;

    logic              acc_clr, acc_en, half_sel, in_result;
    logic [ADDR_W-1:0] byte_addr;
    logic [1:0]        word_ptr;
    logic [HALVES-1:0][7:0] lp_lo, lp_hi, col;

    ecc_byte_sequencer #(.HALF_N(HALF_BYTES), .N_HALF(HALVES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_val  (mode_val),
        .rd_stb    (rd_stb),
        .byte_vld  (byte_vld),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .half_sel  (half_sel),
        .byte_addr (byte_addr),
        .in_result (in_result),
        .word_ptr  (word_ptr)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [LP_W-1:0]  lp_code;
        logic [COL_W-1:0] col_code;
        ecc_half_accum #(.HALF_N(HALF_BYTES), .BYTE_W(DATA_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (acc_clr),
            .en       (acc_en && (half_sel == 1'(h))),
            .addr     (byte_addr),
            .dat      (byte_dat),
            .lp_code  (lp_code),
            .col_code (col_code)
        );
        assign lp_lo[h] = lp_code[7:0];
        assign lp_hi[h] = lp_code[15:8];
        assign col[h]   = col_code;
    end

    ecc_word_mux u_mux (
        .in_result (in_result),
        .word_ptr  (word_ptr),
        .lp_lo     (lp_lo),
        .lp_hi     (lp_hi),
        .col       (col),
        .rd_data   (rd_data)
    );

    assert_first_half_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !half_sel) |=> $stable(lp_lo[1]) && $stable(lp_hi[1]) && $stable(col[1]));
    assert_second_half_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && half_sel) |=> $stable(lp_lo[0]) && $stable(lp_hi[0]) && $stable(col[0]));
endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_val = 8'h00;
    logic        rd_stb = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic [15:0] rd_data;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural model
    int m_state = 0;  // 0 idle 1 cleared 2 primed 3 calc 4 result
    int m_cnt = 0;
    int m_ptr = 0;
    int m_mem [512];

    nand_ecc_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
        .rd_stb(rd_stb), .byte_vld(byte_vld), .byte_dat(byte_dat), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_ptr = 0;
            for (int i = 0; i < 512; i++) m_mem[i] = 0;
        end else if (mode_we) begin
            if (mode_val == 8'hF4) begin
                m_state = 1; m_cnt = 0;
                for (int i = 0; i < 512; i++) m_mem[i] = 0;
            end else if (mode_val == 8'hD4) begin
                m_state = 4; m_ptr = 0;
            end else if (mode_val == 8'hB4) begin
                if (m_state != 1) m_state = 3;
            end else m_state = 0;
        end else begin
            if (m_state == 1 && rd_stb) m_state = 2;
            else if (m_state == 4 && rd_stb) m_ptr = (m_ptr + 1) % 3;
            else if (m_state == 3 && byte_vld && m_cnt < 512) begin
                m_mem[m_cnt] = byte_dat;
                m_cnt++;
            end
        end
    end

    function automatic int code_byte(int h, int which);
        int lp = 0, cp = 0, p, b;
        for (int a = 0; a < 256; a++) begin
            b = m_mem[h*256 + a];
            p = 0;
            for (int i = 0; i < 8; i++) p ^= (b >> i) & 1;
            for (int k = 0; k < 8; k++)
                if (((a >> k) & 1) == 1) lp ^= p << (2*k+1); else lp ^= p << (2*k);
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 3; j++)
                    if (((i >> j) & 1) == 1) cp ^= ((b >> i) & 1) << (2*j+1);
                    else                     cp ^= ((b >> i) & 1) << (2*j);
        end
        if (which == 0) return (~lp) & 255;
        if (which == 1) return ((~lp) >> 8) & 255;
        return ((((~cp) & 63) << 2) | 3);
    endfunction

    function automatic int model_word();
        if (m_state != 4) return 0;
        case (m_ptr)
            0: return (code_byte(0,1) << 8) | code_byte(0,0);
            1: return (code_byte(1,0) << 8) | code_byte(0,2);
            default: return (code_byte(1,2) << 8) | code_byte(1,1);
        endcase
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            int e;
            e = model_word();
            vectors++;
            if (rd_data !== 16'(e)) begin
                fails++;
                $display("FAIL %s model compare: rd_data=%h expected=%h", cur_req, rd_data, 16'(e));
            end
        end
    end

    task automatic check(input string req, input logic [15:0] exp);
        vectors++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_we = 1'b1; mode_val = v;
        @(posedge clk); #1;
        mode_we = 1'b0; mode_val = 8'h00;
    endtask

    task automatic rd_pulse();
        rd_stb = 1'b1;
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic feed(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1;
            byte_dat = 8'((i*73 + seed*11 + (i >> 3)) & 255);
            @(posedge clk); #1;
        end
        byte_vld = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_dat = d;
        @(posedge clk); #1;
        byte_vld = 1'b0;
    endtask

    task automatic arm();
        wr_mode(8'hF4);
        rd_pulse();
        wr_mode(8'hB4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset state
        cur_req = "R1";
        check("R1", 16'h0000);
        wr_mode(8'hD4);
        check("R1", 16'hFFFF); rd_pulse();
        check("R1", 16'hFFFF); rd_pulse();
        check("R1", 16'hFFFF); rd_pulse();

        // R3: calculate without dummy read is ignored
        cur_req = "R3";
        wr_mode(8'hF4);
        wr_mode(8'hB4);
        feed(5, 1);
        wr_mode(8'hD4);
        check("R3", 16'hFFFF); rd_pulse();
        check("R3", 16'hFFFF); rd_pulse();
        check("R3", 16'hFFFF);

        // R7 R8: single set bit at address 0x5A in first half
        cur_req = "R7";
        arm();
        feed(8'h5A, 0);
        wr_mode(8'hF4); rd_pulse(); wr_mode(8'hB4);
        for (int i = 0; i < 8'h5A; i++) put_byte(8'h00);
        put_byte(8'h01);
        wr_mode(8'hD4);
        check("R7", 16'h9966); rd_pulse();
        check("R8", 16'hFFAB); rd_pulse();
        check("R5", 16'hFFFF); rd_pulse();
        check("R10", 16'h9966);

        // R2 R9: clear then erased segment
        cur_req = "R9";
        arm();
        for (int i = 0; i < 512; i++) put_byte(8'hFF);
        wr_mode(8'hD4);
        check("R9", 16'hFFFF); rd_pulse();
        check("R9", 16'hFFFF); rd_pulse();
        check("R9", 16'hFFFF);
        wr_mode(8'hF4);
        wr_mode(8'hD4);
        check("R2", 16'hFFFF);

        // R5 R6 R10: full segment, overrun, wrap-around readout
        cur_req = "R5";
        arm();
        feed(512, 3);
        cur_req = "R6";
        feed(20, 9);
        cur_req = "R10";
        wr_mode(8'hD4);
        for (int r = 0; r < 4; r++) rd_pulse();
        wr_mode(8'h94);

        // R11: other mode stops accumulation, rd_data 0
        cur_req = "R11";
        arm();
        feed(10, 5);
        wr_mode(8'h94);
        check("R11", 16'h0000);
        feed(10, 6);
        // R4: calculate from IDLE resumes
        cur_req = "R4";
        wr_mode(8'hB4);
        feed(3, 7);
        // R12: mode write and byte in same cycle
        cur_req = "R12";
        mode_we = 1'b1; mode_val = 8'hB4; byte_vld = 1'b1; byte_dat = 8'h5C;
        @(posedge clk); #1;
        mode_we = 1'b0; mode_val = 8'h00; byte_vld = 1'b0;
        wr_mode(8'hD4);
        mode_we = 1'b1; mode_val = 8'hD4; rd_stb = 1'b1;
        @(posedge clk); #1;
        mode_we = 1'b0; mode_val = 8'h00; rd_stb = 1'b0;
        rd_pulse(); rd_pulse();

        // R8: second-half single bit 0x80 at in-half address 0xC3
        cur_req = "R8";
        arm();
        for (int i = 0; i < 256 + 8'hC3; i++) put_byte(8'h00);
        put_byte(8'h80);
        wr_mode(8'hD4);
        check("R5", 16'hFFFF); rd_pulse();
        // B: addr 0xC3 = 1100_0011 -> raw LP bits 1,3,4,6,8,10,13,15 ; bit index 7 -> CP1,CP3,CP5
        check("R8", 16'hA5FF); rd_pulse();
        check("R8", 16'h575A);

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule